// File: doc/BRIEF.md
# Traffic Destination Generator for a 16-Node On-Chip Network

This block sits next to the packet source of one node in an on-chip network. Each time the source wants to inject a new packet, it pulses a request. The block then returns the address of the node that should receive that packet. The traffic shape is set by a two-bit pattern select:

- A pseudo-random pick among all other nodes.
- Two permutations of the source's own binary address: bit reversal and half swap (matrix transpose).
- A single shared target node, used to build hot-spot traffic.

The random source is a 16-bit Galois shift register. At reset it is seeded from the node address, so neighbouring nodes walk different sequences.

The result is registered. A valid flag marks a usable destination. A separate self flag marks a request whose pattern would make the node address itself; such a request gets no valid flag. In random mode, any draw that hits the source or lies outside the node count is thrown away, and the register steps again on each following cycle until a usable draw appears.

Top module: `noc_dest_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dest`, `dest_valid` and `self_flag` are all zero.
- R2: For an accepted request in modes 1, 2 or 3, exactly one of `dest_valid` or `self_flag` is high on the cycle after the strobe, and both are low again on the cycle after that unless a new strobe arrives.
- R3: Mode 2'b00 (random) only ever produces addresses below NODES that differ from `src_addr`. Over many requests, every other node address appears.
- R4: Mode 2'b01 returns `src_addr` with its bit order mirrored (bit 0 goes to bit ADDR_W-1, and so on).
- R5: Mode 2'b10 returns `src_addr` with its upper ADDR_W/2 bits and lower ADDR_W/2 bits exchanged.
- R6: Mode 2'b11 returns `hot_addr` for every node other than the hot node itself.
- R7: When a mode 1, 2 or 3 result equals `src_addr`, `self_flag` pulses, `dest` shows that result, and `dest_valid` stays low for the request.
- R8: In random mode, a draw that equals `src_addr` or is not below NODES is never presented. The generator steps once per cycle until an acceptable draw arrives, then raises `dest_valid` for one cycle. Strobes that arrive during this redraw are ignored.
- R9: The shift register loads a non-zero seed built from `src_addr` at reset, so random mode always completes a request within a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle strobe asking for a new destination |
| mode | input | 2 | Pattern select: 0 random, 1 bit mirror, 2 half swap, 3 hot spot |
| src_addr | input | ADDR_W | Address of this node |
| hot_addr | input | ADDR_W | Target node used in hot-spot mode |
| dest | output | ADDR_W | Registered destination address |
| dest_valid | output | 1 | One-cycle flag marking a usable `dest` |
| self_flag | output | 1 | One-cycle flag: the pattern pointed back at the source |

## Verification
The bench targets the sources whose addresses map onto themselves: palindromes under mirroring, equal halves under swapping, and the hot node itself. A design that missed these would emit a valid packet addressed to its own node. In random mode, several hundred draws are collected from one source. A design without the redraw would eventually return the source address. A design with a wrong shift or a poor seed would leave some nodes unreachable, or never complete a request at all. Each result is also checked to drop after exactly one cycle, which catches a flag that is held high or that fires late.

// File: rtl/noc_dest_gen.sv
module noc_dest_gen #(
  parameter int ADDR_W = 4,
  parameter int NODES = 16,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] hot_addr,
  output logic [ADDR_W-1:0] dest,
  output logic              dest_valid,
  output logic              self_flag
);
  localparam int HALF = ADDR_W / 2;
  localparam logic [1:0] M_RAND = 2'd0, M_MIRROR = 2'd1, M_SWAP = 2'd2, M_HOT = 2'd3;

  logic [LFSR_W-1:0] lfsr, lfsr_nxt, seed;
  logic [ADDR_W-1:0] cand, mirror, det;
  logic              cand_ok, pend;

  assign lfsr_nxt = (lfsr >> 1) ^ (lfsr[0] ? LFSR_TAPS : '0);
  assign seed     = (LFSR_SEED ^ (LFSR_W'(src_addr) << 1)) | LFSR_W'(1);
  assign cand     = lfsr_nxt[ADDR_W-1:0];
  assign cand_ok  = (cand != src_addr) && (int'(cand) < NODES);

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) mirror[i] = src_addr[ADDR_W-1-i];
  end

  always_comb begin
    case (mode)
      M_MIRROR: det = mirror;
      M_SWAP:   det = {src_addr[HALF-1:0], src_addr[ADDR_W-1:HALF]};
      M_HOT:    det = hot_addr;
      default:  det = src_addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr       <= seed;
      pend       <= 1'b0;
      dest       <= '0;
      dest_valid <= 1'b0;
      self_flag  <= 1'b0;
    end else begin
      dest_valid <= 1'b0;
      self_flag  <= 1'b0;
      if (pend || (req && mode == M_RAND)) begin
        lfsr <= lfsr_nxt;
        if (cand_ok) begin
          dest       <= cand;
          dest_valid <= 1'b1;
          pend       <= 1'b0;
        end else begin
          pend <= 1'b1;
        end
      end else if (req) begin
        dest <= det;
        if (det == src_addr) self_flag  <= 1'b1;
        else                 dest_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/noc_dest_gen_chk.sv
module noc_dest_gen_chk #(
  parameter int ADDR_W = 4,
  parameter int NODES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] hot_addr,
  input logic [ADDR_W-1:0] dest,
  input logic              dest_valid,
  input logic              self_flag,
  input logic              pend
);
  // R3
  never_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dest_valid |-> dest != src_addr);

  // R8
  in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dest_valid |-> int'(dest) < NODES);

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dest_valid && self_flag));

  // R6
  hot_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !pend && mode == 2'd3 && src_addr != hot_addr) |=> (dest_valid && dest == $past(hot_addr)));

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !pend) |=> (!dest_valid && !self_flag));

  // R7
  self_det_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !pend && mode == 2'd0) |=> !self_flag);
endmodule

bind noc_dest_gen noc_dest_gen_chk #(.ADDR_W(ADDR_W), .NODES(NODES)) chk_i (.*);

// File: tb/noc_dest_gen_tb.sv
module noc_dest_gen_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [3:0] src_addr = 4'd5, hot_addr = 4'd0;
  logic [3:0] dest;
  logic dest_valid, self_flag;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  noc_dest_gen dut_i (.clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .src_addr(src_addr),
    .hot_addr(hot_addr), .dest(dest), .dest_valid(dest_valid), .self_flag(self_flag));

  // mode, src, hot, expected dest, valid, self
  localparam logic [15:0] VEC [0:11] = '{
    {2'd1, 4'h1, 4'h0, 4'h8, 1'b1, 1'b0},
    {2'd1, 4'h2, 4'h0, 4'h4, 1'b1, 1'b0},
    {2'd1, 4'hB, 4'h0, 4'hD, 1'b1, 1'b0},
    {2'd1, 4'h6, 4'h0, 4'h6, 1'b0, 1'b1},
    {2'd2, 4'h1, 4'h0, 4'h4, 1'b1, 1'b0},
    {2'd2, 4'hB, 4'h0, 4'hE, 1'b1, 1'b0},
    {2'd2, 4'hC, 4'h0, 4'h3, 1'b1, 1'b0},
    {2'd2, 4'h5, 4'h0, 4'h5, 1'b0, 1'b1},
    {2'd3, 4'h3, 4'hA, 4'hA, 1'b1, 1'b0},
    {2'd3, 4'h0, 4'hF, 4'hF, 1'b1, 1'b0},
    {2'd3, 4'hA, 4'hA, 4'hA, 1'b0, 1'b1},
    {2'd1, 4'h9, 4'h0, 4'h9, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req_id, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_id, act, exp);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] hits;
    repeat (3) @(negedge clk);
    chk(dest == 0 && !dest_valid && !self_flag, "R1", {dest, dest_valid, self_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dest == 0 && !dest_valid && !self_flag, "R1", {dest, dest_valid, self_flag}, 0);

    // R4 R5 R6 R7 with R2 pulse width
    for (int i = 0; i < 12; i++) begin
      mode = VEC[i][15:14]; src_addr = VEC[i][13:10]; hot_addr = VEC[i][9:6]; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(dest == VEC[i][5:2] && dest_valid == VEC[i][1] && self_flag == VEC[i][0],
          "R4/R5/R6/R7 vector", {dest, dest_valid, self_flag}, VEC[i][5:0]);
      @(negedge clk);
      chk(!dest_valid && !self_flag, "R2", {dest_valid, self_flag}, 0);
    end

    // back-to-back strobes, R2
    mode = 2'd3; src_addr = 4'h1; hot_addr = 4'h7; req = 1'b1;
    @(negedge clk);
    chk(dest_valid && dest == 4'h7, "R2 R6 back-to-back", {dest, dest_valid}, {4'h7, 1'b1});
    hot_addr = 4'h2;
    @(negedge clk);
    req = 1'b0;
    chk(dest_valid && dest == 4'h2, "R2 R6 back-to-back", {dest, dest_valid}, {4'h2, 1'b1});

    // random mode: R3 R8 R9
    rst_n = 1'b0; mode = 2'd0; src_addr = 4'd5;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    hits = '0;
    for (int n = 0; n < 300; n++) begin
      int wait_cyc;
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      wait_cyc = 0;
      while (!dest_valid && wait_cyc < 64) begin
        @(negedge clk);
        wait_cyc++;
      end
      chk(dest_valid, "R9 completes", wait_cyc, 64);
      chk(dest != src_addr && !self_flag, "R3 R8 not self", dest, 16);
      if (dest_valid) hits[dest] = 1'b1;
      @(negedge clk);
    end
    for (int a = 0; a < 16; a++) begin
      if (a == 5) chk(!hits[a], "R3 source absent", hits[a], 0);
      else        chk(hits[a], "R3 coverage", a, a);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule